// File: doc/BRIEF.md
# Bit-Error Checker with Leaky-Bucket Lock Guard

This block sits behind a clock-recovery and line-decoding stage. That stage hands it one recovered data bit at a time, each marked by a single-cycle strobe in the system clock domain. The block keeps its own copy of the expected pseudo-random test pattern. It compares every received bit against that pattern and counts the mismatches over a measurement window of programmable length. The window is timed in system clock cycles. At the end of each window the block presents the error total and the bit total together with a one-cycle done pulse.

Lock is guarded by a leaky bucket. While locked, every mismatching bit pours a weighted amount into the bucket and every matching bit lets a fixed amount drain out. When the bucket would rise above its capacity, the checker drops lock and starts hunting again. This lets isolated errors pass without losing lock, while a misaligned stream is detected within a bounded number of bits. A two-bit sensitivity setting picks the inflow weight.

While hunting, the local pattern register is filled directly from the received bits. Lock is declared once enough consecutive bits have been predicted correctly.

Top module: `ber_checker`

## Requirements
- R1: After reset, in_sync, done, err_count and bit_count are all 0.
- R2: The expected bit for each strobed bit is the XOR of the bits received 7 and 6 strobes earlier, i.e. the pattern obeys b[n] = b[n-7] ^ b[n-6]. While locked, that history is the locally generated pattern. A locked stream that follows the pattern adds no errors, and each flipped bit adds exactly one error.
- R3: While unlocked, each received bit is shifted into the pattern history. in_sync rises on the strobe that completes 64 consecutive correct predictions, and not one strobe earlier.
- R4: Mismatches are counted only while locked, including the mismatch that causes loss of lock. Bits received while unlocked add nothing to err_count.
- R5: Each mismatch while locked adds 4 << sens to the bucket level. Lock is lost on the mismatch that would take the level above 256, so from an empty bucket lock is lost on consecutive error number 65, 33, 17 or 9 for sens = 0, 1, 2 or 3.
- R6: Each matching bit while locked lowers the level by 1.
- R7: Draining stops at zero. Matching bits on an empty bucket do not make the level wrap.
- R8: The bucket level is cleared when lock is acquired.
- R9: A done pulse lasting one cycle occurs every gate_len clock cycles. With it, bit_count and err_count take the totals of that window only, counting the strobe in the closing cycle, and the running totals restart.
- R10: A new gate_len takes effect no later than the window after the current one. gate_len must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Strobe marking a valid recovered bit |
| rx_bit | input | 1 | Recovered data bit |
| sens | input | 2 | Sensitivity: inflow weight 4 << sens |
| gate_len | input | GATE_W | Window length in clock cycles |
| in_sync | output | 1 | Lock status |
| done | output | 1 | One-cycle pulse when a window closes |
| err_count | output | CNT_W | Mismatch total of the last window |
| bit_count | output | CNT_W | Bit total of the last window |

## Verification
The checker is fed four kinds of bit stream. A constant-ones stream can never lock, so it shows that nothing is counted while hunting. A clean pattern shows the exact lock point and a zero error total. Runs of consecutive flipped bits are sent at every sensitivity level, and they separate the four overflow thresholds and show the bucket being cleared on relock. Errors mixed with matches separate correct draining and zero saturation from a level that wraps or never drains. The windows are measured at two gate lengths, and each window is checked against its arithmetic bit total.

// File: rtl/ber_pkg.sv
// Shared types for the bit-error checker.
// Assumes the sensitivity code is a two-bit shift amount applied to the inflow base.
package ber_pkg;
    typedef enum logic [1:0] {
        SENS_X4  = 2'd0,
        SENS_X8  = 2'd1,
        SENS_X16 = 2'd2,
        SENS_X32 = 2'd3
    } sens_e;
endpackage

// File: rtl/ber_ref_gen.sv
// Local pattern generator and bit comparator.
// Predicts each received bit from the last LEN bits of history.
// While hunting, the history is filled from the received data; while locked it runs free.
// Assumes bit_en marks exactly one clock per recovered bit.
module ber_ref_gen #(
    parameter int unsigned LEN  = 7,
    parameter logic [LEN-1:0] TAPS = 7'h60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic hunting,
    output logic mismatch
);
    logic [LEN-1:0] hist;
    logic           expected;

    // Prediction of the current bit and its comparison with the received one
    always_comb begin
        expected = ^(hist & TAPS);
        mismatch = expected ^ rx_bit;
    end

    // Advance the history by one bit per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (bit_en) begin
            hist <= {hist[LEN-2:0], hunting ? rx_bit : expected};
        end
    end
endmodule

// File: rtl/ber_sync_bucket.sv
// Lock tracker: run counter while hunting, leaky bucket while locked.
// Assumes mismatch is valid in every cycle where bit_en is high.
module ber_sync_bucket
    import ber_pkg::*;
#(
    parameter int unsigned CAPACITY   = 256,
    parameter int unsigned INLET_BASE = 4,
    parameter int unsigned OUTLET     = 1,
    parameter int unsigned LOCK_RUN   = 64
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_en,
    input  logic  mismatch,
    input  sens_e sens,
    output logic  in_sync
);
    localparam int unsigned LW = $clog2(CAPACITY + (INLET_BASE << 3) + 1) + 1;
    localparam int unsigned RW = $clog2(LOCK_RUN + 1);
    localparam logic [LW-1:0] CAP_L  = LW'(CAPACITY);
    localparam logic [LW-1:0] OUT_L  = LW'(OUTLET);
    localparam logic [RW-1:0] RUN_TOP = RW'(LOCK_RUN - 1);

    logic [LW-1:0] level;
    logic [LW-1:0] inlet;
    logic [LW-1:0] filled;
    logic [RW-1:0] run;

    // Inflow weight for the chosen sensitivity and the level it would give
    always_comb begin
        inlet  = LW'(INLET_BASE) << sens;
        filled = level + inlet;
    end

    // Hunt/lock state, run of correct predictions and bucket level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync <= 1'b0;
            level   <= '0;
            run     <= '0;
        end else if (bit_en) begin
            if (!in_sync) begin
                if (mismatch) begin
                    run <= '0;
                end else if (run == RUN_TOP) begin
                    in_sync <= 1'b1;
                    level   <= '0;
                    run     <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end else if (mismatch) begin
                if (filled > CAP_L) begin
                    in_sync <= 1'b0;
                    run     <= '0;
                end else begin
                    level <= filled;
                end
            end else begin
                level <= (level > OUT_L) ? level - OUT_L : '0;
            end
        end
    end
endmodule

// File: rtl/ber_gate.sv
// Measurement window: counts clock cycles up to gate_len, then latches the
// running error and bit totals and restarts them.
// Assumes gate_len >= 2.
module ber_gate #(
    parameter int unsigned GW = 24,
    parameter int unsigned CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          err_hit,
    input  logic [GW-1:0] gate_len,
    output logic          done,
    output logic [CW-1:0] err_count,
    output logic [CW-1:0] bit_count
);
    logic [GW-1:0] tick;
    logic [CW-1:0] err_run;
    logic [CW-1:0] bit_run;
    logic [CW-1:0] err_inc;
    logic [CW-1:0] bit_inc;
    logic          last;

    // Per-cycle increments and window end detection
    always_comb begin
        err_inc = CW'(bit_en & err_hit);
        bit_inc = CW'(bit_en);
        last    = tick >= gate_len - GW'(1);
    end

    // Window timer, running totals and latched results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick      <= '0;
            err_run   <= '0;
            bit_run   <= '0;
            err_count <= '0;
            bit_count <= '0;
            done      <= 1'b0;
        end else begin
            done <= last;
            if (last) begin
                tick      <= '0;
                err_count <= err_run + err_inc;
                bit_count <= bit_run + bit_inc;
                err_run   <= '0;
                bit_run   <= '0;
            end else begin
                tick    <= tick + 1'b1;
                err_run <= err_run + err_inc;
                bit_run <= bit_run + bit_inc;
            end
        end
    end
endmodule

// File: rtl/ber_checker.sv
// Top of the bit-error checker: pattern comparator, lock tracker and
// measurement window. Assumes bits arrive as single-cycle strobes in the clk domain.
module ber_checker #(
    parameter int unsigned PRBS_LEN   = 7,
    parameter logic [PRBS_LEN-1:0] PRBS_TAPS = 7'h60,
    parameter int unsigned CAPACITY   = 256,
    parameter int unsigned INLET_BASE = 4,
    parameter int unsigned OUTLET     = 1,
    parameter int unsigned LOCK_RUN   = 64,
    parameter int unsigned GATE_W     = 24,
    parameter int unsigned CNT_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic [1:0]        sens,
    input  logic [GATE_W-1:0] gate_len,
    output logic              in_sync,
    output logic              done,
    output logic [CNT_W-1:0]  err_count,
    output logic [CNT_W-1:0]  bit_count
);
    logic          mismatch;
    logic          err_hit;
    ber_pkg::sens_e sens_t;

    // Typed sensitivity and the error qualifier (only counted while locked)
    always_comb begin
        sens_t  = ber_pkg::sens_e'(sens);
        err_hit = mismatch & in_sync;
    end

    ber_ref_gen #(.LEN(PRBS_LEN), .TAPS(PRBS_TAPS)) ref_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .hunting(!in_sync), .mismatch(mismatch)
    );

    ber_sync_bucket #(
        .CAPACITY(CAPACITY), .INLET_BASE(INLET_BASE),
        .OUTLET(OUTLET), .LOCK_RUN(LOCK_RUN)
    ) bucket_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mismatch(mismatch),
        .sens(sens_t), .in_sync(in_sync)
    );

    ber_gate #(.GW(GATE_W), .CW(CNT_W)) gate_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .err_hit(err_hit),
        .gate_len(gate_len), .done(done),
        .err_count(err_count), .bit_count(bit_count)
    );
endmodule

// File: rtl/ber_checker_chk.sv
// Property checker for ber_checker, attached through bind.
// Assumes gate_len >= 2 throughout.
module ber_checker_chk #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             in_sync,
    input logic             done,
    input logic [CNT_W-1:0] err_count,
    input logic [CNT_W-1:0] bit_count
);
    // R3
    lock_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(bit_en));

    // R5
    sync_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(in_sync));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(err_count) && $stable(bit_count)));

    // R4
    err_le_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_count <= bit_count));
endmodule

bind ber_checker ber_checker_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/ber_checker_tb_top.sv
module ber_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        rx_bit = 1'b0;
    logic [1:0]  sens = 2'd0;
    logic [23:0] gate_len = 24'd400;
    logic        in_sync;
    logic        done;
    logic [23:0] err_count;
    logic [23:0] bit_count;

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    int cap_err = 0;
    int cap_bits = 0;
    bit finished = 1'b0;
    logic [6:0] hist = 7'h7F;

    always #2.5 clk = ~clk;

    ber_checker dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .sens(sens), .gate_len(gate_len), .in_sync(in_sync), .done(done),
        .err_count(err_count), .bit_count(bit_count)
    );

    // capture window results away from the clock edge
    always @(negedge clk) begin
        if (done) begin
            cap_err  = int'(err_count);
            cap_bits = int'(bit_count);
            done_cnt = done_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        rx_bit = b;
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // next pattern bit b[n] = b[n-7] ^ b[n-6], optionally flipped
    task automatic send_prbs(input logic flip);
        logic nb;
        nb = hist[6] ^ hist[5];
        hist = {hist[5:0], nb};
        send_raw(nb ^ flip);
    endtask

    task automatic wait_done();
        int n;
        n = done_cnt;
        while (done_cnt == n) send_prbs(1'b0);
    endtask

    task automatic relock();
        for (int i = 0; i < 80; i++) send_prbs(1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 in_sync", int'(in_sync), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err_count", int'(err_count), 0);
        chk("R1 bit_count", int'(bit_count), 0);

        // R4: a stream that never locks counts no errors; R9 window bit total
        for (int i = 0; i < 220; i++) send_raw(1'b1);
        chk("R4 hunting in_sync", int'(in_sync), 0);
        chk("R4 hunting errors", cap_err, 0);
        chk("R9 window bits", cap_bits, 100);

        // R3: lock on the 64th consecutive correct prediction
        for (int i = 1; i <= 64; i++) begin
            send_prbs(1'b0);
            if (i == 63) chk("R3 not yet locked", int'(in_sync), 0);
            if (i == 64) chk("R3 locked", int'(in_sync), 1);
        end

        // R2: three flipped bits in one window, then a clean window
        wait_done();
        for (int i = 0; i < 10; i++) send_prbs((i == 2 || i == 5 || i == 8) ? 1'b1 : 1'b0);
        wait_done();
        chk("R2 errors counted", cap_err, 3);
        chk("R9 bits per window", cap_bits, 100);
        chk("R2 still locked", int'(in_sync), 1);
        wait_done();
        chk("R2 clean window", cap_err, 0);

        // R5 thresholds per sensitivity; R8 level cleared on each relock
        for (int s = 0; s < 4; s++) begin
            int thr;
            sens = 2'(s);
            thr = 256 / (4 << s);
            for (int k = 0; k < thr; k++) send_prbs(1'b1);
            chk($sformatf("R5 sens%0d at capacity", s), int'(in_sync), 1);
            send_prbs(1'b1);
            chk($sformatf("R5 sens%0d overflow", s), int'(in_sync), 0);
            relock();
            chk($sformatf("R8 relock after sens%0d", s), int'(in_sync), 1);
        end

        // R6: drain of one per matching bit
        sens = 2'd3;
        for (int k = 0; k < 8; k++) send_prbs(1'b1);
        chk("R6 full bucket", int'(in_sync), 1);
        for (int k = 0; k < 32; k++) send_prbs(1'b0);
        send_prbs(1'b1);
        chk("R6 drained 32", int'(in_sync), 1);
        send_prbs(1'b1);
        chk("R6 overflow after drain", int'(in_sync), 0);
        relock();

        // R7: level saturates at zero
        for (int k = 0; k < 50; k++) send_prbs(1'b0);
        for (int k = 0; k < 8; k++) send_prbs(1'b1);
        chk("R7 no wrap", int'(in_sync), 1);
        send_prbs(1'b1);
        chk("R7 overflow", int'(in_sync), 0);
        relock();

        // R4: overflow error counted, hunting errors not
        wait_done();
        for (int k = 0; k < 9; k++) send_prbs(1'b1);
        for (int k = 0; k < 20; k++) send_raw(1'b1);
        wait_done();
        chk("R4 errors only while locked", cap_err, 9);

        // R10: shorter window
        gate_len = 24'd200;
        wait_done();
        wait_done();
        chk("R10 bits in short window", cap_bits, 50);
        chk("R10 clean short window", cap_err, 0);
        chk("R10 locked", int'(in_sync), 1);

        finish_run();
    end
endmodule